// File: doc/BRIEF.md
# Auto-masking priority interrupt controller

This controller collects level-sensitive interrupt lines from several dies, each die contributing a fixed number of lines set by a parameter. Each line's request is the OR of its hardware input and a software trigger bit held in the block. A per-line mask gates the request, and per-CPU routing vectors decide which CPUs can see it. Every CPU has one event port. A read returns a word naming the lowest-numbered pending, unmasked, routed line, and the same read acknowledges that line by setting its mask bit.

Software changes masks, triggers and routing through a plain valid/opcode/data write port. Each data bit stands for one line. A registered interrupt output per CPU tells that CPU whether anything is waiting for it. Because every line is level-sensitive, clearing the mask of a line whose source is still high makes it pending again.

Each CPU port is a two-state machine. PORT_IDLE waits for a read. ISSUE (PORT_IDLE to PORT_IDLE on no read, PORT_IDLE to PORT_RESP on a read) captures the event word. In PORT_RESP, CHAIN (PORT_RESP to PORT_RESP on a further read) serves back-to-back reads, and RETIRE (PORT_RESP to PORT_IDLE with no read) ends the response.

Top module: `intc_auto_mask`

## Requirements
- R1: After reset every mask bit is set, every software trigger is clear, all lines route to CPU 0 only and to no other CPU, and all `irq_out` and `rd_ack` bits are low.
- R2: A line's request is its hardware input level OR its software trigger. `irq_out[c]` equals, one clock later, whether CPU c has at least one request that is unmasked and routed to it.
- R3: A masked line is never delivered and never raises `irq_out`, even while its input is high.
- R4: Setting a software trigger makes the line pending with no hardware input. Clearing the trigger removes that request.
- R5: Among the candidates for a CPU, the line with the lowest global index (die × lines-per-die + number) is delivered first.
- R6: A read pulse `rd_req[c]` is answered on the next cycle by `rd_ack[c]` high and `rd_event` slice c holding {1'b1 type bit (MSB), die index, line number in the low bits}. The word is all zeros when nothing is pending. With the default parameters a line L gives 16+L.
- R7: The clock edge that registers a delivered event also sets that line's mask bit, so a repeated read returns the next candidate or zero.
- R8: Clearing the mask of a line whose request is still high makes it deliverable again, with no new edge needed.
- R9: A line is visible only to the event port and `irq_out` of the CPUs whose routing vector has its bit set.
- R10: When several CPUs read in the same cycle, each gets its own result. A line routed to more than one of them goes only to the lowest-numbered reading CPU, and the next one gets its next candidate.
- R11: Write opcodes: 0 sets the masks of the lines whose `wr_data` bits are set, 1 clears those masks, 2 sets those triggers, 3 clears those triggers, and 4+c loads `wr_data` as the routing vector of CPU c.
- R12: If a write clears the mask of a line in the same cycle that line is delivered, the delivery wins and the mask ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_DIES*LINES_PER_DIE | Level hardware requests, die-major order |
| wr_valid | input | 1 | Write strobe |
| wr_op | input | OP_W | Write opcode (R11) |
| wr_data | input | NUM_DIES*LINES_PER_DIE | One bit per line |
| rd_req | input | NUM_CPUS | Per-CPU event read pulse |
| rd_ack | output | NUM_CPUS | Per-CPU read response valid |
| rd_event | output | NUM_CPUS*EV_W | Per-CPU event words, CPU 0 in the low slice |
| irq_out | output | NUM_CPUS | Registered per-CPU interrupt request |

## Verification
Two lines on different dies are raised together, which shows whether the index order is respected across the die boundary. Repeated reads then show that auto-masking advances delivery until the port reports zero. A line held high while masked, and a line driven only by its software trigger, separate the mask gate from the OR of hardware and software requests. Re-opening a still-high line checks level behaviour. Split and overlapping routing vectors, read by both CPUs in one cycle, show whether exclusive routing and lowest-CPU arbitration work. A mask clear that lands on the same edge as a delivery shows which of the two takes effect.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    localparam int OP_MASK_SET   = 0;
    localparam int OP_MASK_CLR   = 1;
    localparam int OP_TRIG_SET   = 2;
    localparam int OP_TRIG_CLR   = 3;
    localparam int OP_ROUTE_BASE = 4;
endpackage

// File: rtl/ic_line_regs.sv
module ic_line_regs
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CPUS  = 2,
    parameter int OP_W      = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_valid,
    input  logic [OP_W-1:0]                     wr_op,
    input  logic [NUM_LINES-1:0]                wr_data,
    input  logic [NUM_LINES-1:0]                deliver,
    output logic [NUM_LINES-1:0]                mask_q,
    output logic [NUM_LINES-1:0]                trig_q,
    output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  route_q
);
    logic [NUM_LINES-1:0]               mask_d, trig_d;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] route_d;

    always_comb begin
        mask_d  = mask_q;
        trig_d  = trig_q;
        route_d = route_q;
        if (wr_valid) begin
            if (wr_op == OP_W'(OP_MASK_SET)) mask_d = mask_q | wr_data;
            if (wr_op == OP_W'(OP_MASK_CLR)) mask_d = mask_q & ~wr_data;
            if (wr_op == OP_W'(OP_TRIG_SET)) trig_d = trig_q | wr_data;
            if (wr_op == OP_W'(OP_TRIG_CLR)) trig_d = trig_q & ~wr_data;
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (wr_op == OP_W'(OP_ROUTE_BASE + c)) route_d[c] = wr_data;
            end
        end
        // delivery overrides any mask clear in the same cycle
        mask_d = mask_d | deliver;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            trig_q  <= '0;
            for (int c = 0; c < NUM_CPUS; c++) begin
                route_q[c] <= (c == 0) ? {NUM_LINES{1'b1}} : {NUM_LINES{1'b0}};
            end
        end else begin
            mask_q  <= mask_d;
            trig_q  <= trig_d;
            route_q <= route_d;
        end
    end
endmodule

// File: rtl/ic_prio_pick.sv
module ic_prio_pick #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_LINES-1:0] cand,
    output logic                 found,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] onehot
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // scan downward so the lowest set bit is the last one written
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        onehot = found ? (NUM_LINES'(1) << idx) : '0;
    end
endmodule

// File: rtl/ic_cpu_port.sv
module ic_cpu_port
    import intc_pkg::*;
#(
    parameter int LINES_PER_DIE = 8,
    parameter int IDX_W         = 4,
    parameter int DIE_W         = 1,
    parameter int NUM_W         = 3,
    parameter int EV_W          = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             found,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_ack,
    output logic [EV_W-1:0]  rd_event
);
    port_state_e state_q, state_d;
    logic [EV_W-1:0] word_d, word_q;
    logic [DIE_W-1:0] die_f;
    logic [NUM_W-1:0] num_f;

    always_comb begin
        die_f  = DIE_W'(int'(idx) / LINES_PER_DIE);
        num_f  = NUM_W'(int'(idx) % LINES_PER_DIE);
        word_d = found ? {1'b1, die_f, num_f} : '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: state_d = rd_req ? PORT_RESP : PORT_IDLE;   // ISSUE
            PORT_RESP: state_d = rd_req ? PORT_RESP : PORT_IDLE;   // CHAIN / RETIRE
            default:   state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (rd_req) word_q <= word_d;
    end

    assign rd_ack   = (state_q == PORT_RESP);
    assign rd_event = word_q;
endmodule

// File: rtl/intc_auto_mask.sv
module intc_auto_mask
    import intc_pkg::*;
#(
    parameter int NUM_DIES      = 2,
    parameter int LINES_PER_DIE = 8,
    parameter int NUM_CPUS      = 2,
    localparam int NUM_LINES    = NUM_DIES * LINES_PER_DIE,
    localparam int DIE_W        = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1,
    localparam int NUM_W        = (LINES_PER_DIE > 1) ? $clog2(LINES_PER_DIE) : 1,
    localparam int EV_W         = 1 + DIE_W + NUM_W,
    localparam int IDX_W        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int OP_W         = $clog2(OP_ROUTE_BASE + NUM_CPUS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LINES-1:0]     irq_lines,
    input  logic                     wr_valid,
    input  logic [OP_W-1:0]          wr_op,
    input  logic [NUM_LINES-1:0]     wr_data,
    input  logic [NUM_CPUS-1:0]      rd_req,
    output logic [NUM_CPUS-1:0]      rd_ack,
    output logic [NUM_CPUS*EV_W-1:0] rd_event,
    output logic [NUM_CPUS-1:0]      irq_out
);
    logic [NUM_LINES-1:0]               mask_q, trig_q, live;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] route_q;
    logic [NUM_CPUS:0][NUM_LINES-1:0]   taken;
    logic [NUM_CPUS-1:0]                cpu_live, irq_q;

    ic_line_regs #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .OP_W(OP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_op(wr_op),
        .wr_data(wr_data), .deliver(taken[NUM_CPUS]),
        .mask_q(mask_q), .trig_q(trig_q), .route_q(route_q)
    );

    assign live     = (irq_lines | trig_q) & ~mask_q;
    assign taken[0] = '0;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [NUM_LINES-1:0] cand, oh;
        logic                 found;
        logic [IDX_W-1:0]     idx;

        // lines already claimed by a lower CPU this cycle are hidden
        assign cand        = live & route_q[c] & ~taken[c];
        assign cpu_live[c] = |(live & route_q[c]);

        ic_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
            .cand(cand), .found(found), .idx(idx), .onehot(oh)
        );

        assign taken[c+1] = taken[c] | (rd_req[c] ? oh : {NUM_LINES{1'b0}});

        ic_cpu_port #(
            .LINES_PER_DIE(LINES_PER_DIE), .IDX_W(IDX_W), .DIE_W(DIE_W),
            .NUM_W(NUM_W), .EV_W(EV_W)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .rd_req(rd_req[c]), .found(found), .idx(idx),
            .rd_ack(rd_ack[c]), .rd_event(rd_event[c*EV_W +: EV_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= cpu_live;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
    parameter int NUM_DIES      = 2,
    parameter int LINES_PER_DIE = 8,
    parameter int NUM_CPUS      = 2,
    localparam int NUM_LINES    = NUM_DIES * LINES_PER_DIE,
    localparam int DIE_W        = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1,
    localparam int NUM_W        = (LINES_PER_DIE > 1) ? $clog2(LINES_PER_DIE) : 1,
    localparam int EV_W         = 1 + DIE_W + NUM_W,
    localparam int IDX_W        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CPUS-1:0]      rd_req,
    input logic [NUM_CPUS-1:0]      rd_ack,
    input logic [NUM_CPUS*EV_W-1:0] rd_event,
    input logic [NUM_CPUS-1:0]      irq_out,
    input logic [NUM_CPUS-1:0]      cpu_live,
    input logic [NUM_LINES-1:0]     mask
);
    logic [NUM_LINES-1:0] mask_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) mask_prev <= '1;
        else        mask_prev <= mask;
    end

    assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(cpu_live));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
        logic [EV_W-1:0]  ev;
        logic [IDX_W-1:0] li;
        assign ev = rd_event[c*EV_W +: EV_W];
        assign li = IDX_W'(int'(ev[EV_W-2 -: DIE_W]) * LINES_PER_DIE + int'(ev[NUM_W-1:0]));

        assert_ack_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[c] |=> rd_ack[c]);
        assert_no_spurious_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_req[c] |=> !rd_ack[c]);
        assert_event_type_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_ack[c] && ev != '0) |-> ev[EV_W-1]);
        assert_delivered_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_ack[c] && ev != '0) |-> mask[li]);
        assert_delivered_was_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_ack[c] && ev != '0 && $rose(rd_ack[c])) |-> !mask_prev[li]);

        for (genvar d = c + 1; d < NUM_CPUS; d++) begin : g_pair
            assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_ack[c] && rd_ack[d] && ev != '0) |-> (ev != rd_event[d*EV_W +: EV_W]));
        end
    end
endmodule

bind intc_auto_mask ic_checker #(
    .NUM_DIES(NUM_DIES), .LINES_PER_DIE(LINES_PER_DIE), .NUM_CPUS(NUM_CPUS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack), .rd_event(rd_event),
    .irq_out(irq_out), .cpu_live(cpu_live), .mask(mask_q)
);

// File: tb/sim_intc_auto_mask.sv
module sim_intc_auto_mask;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_op = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_req = '0;
    logic [1:0]  rd_ack;
    logic [9:0]  rd_event;
    logic [1:0]  irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int q0[$];
    int q1[$];
    string t0[$];
    string t1[$];

    always #5 clk = ~clk;

    intc_auto_mask u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_valid(wr_valid),
        .wr_op(wr_op), .wr_data(wr_data), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_event(rd_event), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int op, input int data);
        @(negedge clk);
        wr_valid = 1'b1; wr_op = 3'(op); wr_data = 16'(data);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input int cpu, input int exp, input string tag);
        @(negedge clk);
        rd_req[cpu] = 1'b1;
        if (cpu == 0) begin q0.push_back(exp); t0.push_back(tag); end
        else          begin q1.push_back(exp); t1.push_back(tag); end
        @(negedge clk);
        rd_req = '0;
    endtask

    task automatic rd_both(input int e0, input int e1, input string tag);
        @(negedge clk);
        rd_req = 2'b11;
        q0.push_back(e0); t0.push_back(tag);
        q1.push_back(e1); t1.push_back(tag);
        @(negedge clk);
        rd_req = '0;
    endtask

    // monitor: pop expected words when the design answers
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_ack[0]) begin
                if (q0.size() == 0) chk(1'b0, "R6 cpu0 unexpected ack", 1, 0);
                else begin
                    int e; string tg;
                    e = q0.pop_front(); tg = t0.pop_front();
                    chk(int'(rd_event[4:0]) == e, tg, int'(rd_event[4:0]), e);
                end
            end
            if (rd_ack[1]) begin
                if (q1.size() == 0) chk(1'b0, "R6 cpu1 unexpected ack", 1, 0);
                else begin
                    int e; string tg;
                    e = q1.pop_front(); tg = t1.pop_front();
                    chk(int'(rd_event[9:5]) == e, tg, int'(rd_event[9:5]), e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_out == 2'b00, "R1 irq after reset", int'(irq_out), 0);
        chk(rd_ack == 2'b00, "R1 ack after reset", int'(rd_ack), 0);

        // R1/R3: line high but masked from reset
        irq_lines = 16'h0008;
        rd(0, 0, "R3 masked line not delivered");
        @(negedge clk);
        chk(irq_out == 2'b00, "R3 irq stays low while masked", int'(irq_out), 0);

        // R11 opcode 1 clears masks; nothing pending gives zero (R6)
        irq_lines = '0;
        wr(1, 16'hFFFF);
        rd(0, 0, "R6 empty read returns zero");

        // R2/R9: irq one cycle after request, default route CPU 0 only (R1)
        @(negedge clk);
        irq_lines = 16'h0220;
        @(negedge clk);
        chk(irq_out == 2'b01, "R2 irq timing and R1 default route", int'(irq_out), 1);
        // R5 across dies, R7 auto-mask
        rd(0, 16 + 5, "R5 lowest line first");
        rd(0, 16 + 9, "R7 delivered line masked, next candidate");
        rd(0, 0, "R7 all delivered lines masked");
        repeat (2) @(negedge clk);
        chk(irq_out == 2'b00, "R7 irq drops after auto-mask", int'(irq_out), 0);

        // R8: re-open a still-high line
        wr(1, 16'h0020);
        rd(0, 16 + 5, "R8 unmasked high line re-delivered");

        // R4: software trigger
        irq_lines = '0;
        wr(1, 16'hFFFF);
        wr(2, 16'h1000);
        rd(0, 16 + 12, "R4 software trigger delivered");
        wr(3, 16'h1000);
        wr(1, 16'h1000);
        rd(0, 0, "R4 cleared trigger removes request");

        // R9: split routing
        wr(5, 16'h0004);
        wr(4, 16'hFFFB);
        @(negedge clk);
        irq_lines = 16'h0004;
        @(negedge clk);
        chk(irq_out == 2'b10, "R9 irq only on routed CPU", int'(irq_out), 2);
        rd(0, 0, "R9 unrouted CPU sees nothing");
        rd(1, 16 + 2, "R9 routed CPU receives line");

        // R10: simultaneous reads of shared lines
        irq_lines = '0;
        wr(1, 16'hFFFF);
        wr(4, 16'hFFFF);
        wr(5, 16'hFFFF);
        @(negedge clk);
        irq_lines = 16'h00C0;
        rd_both(16 + 6, 16 + 7, "R10 shared line to lower CPU, next to other");
        rd_both(0, 0, "R10 both lines consumed");

        // R12: mask clear and delivery in the same cycle
        irq_lines = '0;
        wr(1, 16'hFFFF);
        @(negedge clk);
        irq_lines = 16'h0010;
        @(negedge clk);
        wr_valid = 1'b1; wr_op = 3'd1; wr_data = 16'h0010;
        rd_req[0] = 1'b1;
        q0.push_back(16 + 4); t0.push_back("R12 delivery in write cycle");
        @(negedge clk);
        wr_valid = 1'b0; rd_req = '0;
        rd(0, 0, "R12 delivery mask wins over clear");
        rd(1, 0, "R12 line stays masked for other CPU");

        // R11 opcode 0 sets a mask on a high line
        wr(1, 16'hFFFF);
        irq_lines = 16'h0040;
        wr(0, 16'h0040);
        rd(1, 0, "R11 mask-set op hides line");
        @(negedge clk);
        chk(irq_out == 2'b00, "R11 irq low after mask-set", int'(irq_out), 0);

        repeat (3) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R6 all reads answered",
            q0.size() + q1.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule